// File: doc/BRIEF.md
# Serial Absolute Position Reader

This block is the host-side master of a three-wire serial link to a resolver-to-digital converter. The converter always holds the absolute shaft angle, so the host never has to home the axis after a power loss. It only has to ask. A one-cycle request starts a read transaction. The block drives an active-low select and a serial clock, which it derives from the system clock with a programmable divider. It then collects the bits that the converter puts on its data line.

Each frame carries a leading void bit and then twelve significant position bits, most significant first. The converter launches every bit on a falling edge of the serial clock. The master therefore samples on the rising edge that follows, half a serial period later, and never races the launch. After the last bit the block drops the void bit and updates a right-aligned 12-bit position register. It then releases the select and raises a one-cycle completion pulse that can serve as an interrupt to the host.

Top module: `abs_pos_reader`

## Requirements
- R1: A request (`req_i` high for a cycle) received while `sel_n_o` is high makes `sel_n_o` go low at the next clock edge. The serial clock stays high for one full half-period after that.
- R2: Out of reset, `sel_n_o` and `sclk_o` are both high, `done_o` is low and `pos_o` is zero. Whenever `sel_n_o` is high, `sclk_o` is high.
- R3: Every serial clock level, including the first one after `sel_n_o` falls, lasts exactly H system clocks. H is the value of `half_div_i` captured on the accepted request. The serial clock changes only while `sel_n_o` is low.
- R4: A frame has exactly 13 falling edges of `sclk_o` and 13 rising edges. `sdata_i` is sampled on each rising edge.
- R5: The first sampled bit is void and is discarded. The next 12 samples form `pos_o`, with the first of them in bit 11 and the last in bit 0.
- R6: `sel_n_o` returns high exactly H system clocks after the 13th rising edge of `sclk_o`. At that same edge `done_o` goes high and `pos_o` takes the new word.
- R7: `done_o` is high for exactly one clock cycle per frame.
- R8: `pos_o` changes only in the cycle in which `done_o` is high. Between frames it holds its value.
- R9: A request that arrives while a frame is in progress (`sel_n_o` low) is ignored. It neither alters the running frame nor starts another one afterwards.
- R10: A `half_div_i` value of 0 or 1 is treated as 2, so H is never below 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | One-cycle read request |
| half_div_i | input | 8 | Serial clock half-period in system clocks, captured at request |
| sdata_i | input | 1 | Serial data from the converter, launched on falling serial clock edges |
| sel_n_o | output | 1 | Active-low select to the converter |
| sclk_o | output | 1 | Serial clock, idles high |
| pos_o | output | 12 | Last captured absolute position, right-aligned |
| done_o | output | 1 | One-cycle frame-complete pulse, usable as an interrupt |

## Verification
The assertions take two things for granted: the converter changes `sdata_i` only on falling serial clock edges, and `half_div_i` matters only in the cycle where a request is accepted. The bench's converter model updates the data line on each falling edge of `sclk_o` and puts random garbage on it before the first edge. The bench applies the divider together with the request. Random frames use divider values from 2 to 12 and random 12-bit words with random void bits. Directed cases add divider values 0 and 1, all-zero and all-one words, and a request pulsed in the middle of a frame.

// File: rtl/rdr_pkg.sv
package rdr_pkg;

   typedef enum logic [1:0] {
      RDR_IDLE  = 2'd0,
      RDR_SHIFT = 2'd1,
      RDR_TAIL  = 2'd2
   } rdr_state_e;

   localparam int RDR_MIN_HALF = 2;

   function automatic int rdr_cnt_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/rdr_half_timer.sv
module rdr_half_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             run_i,
   output logic             tick_o
);
   localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(rdr_pkg::RDR_MIN_HALF);

   logic [DIV_W-1:0] eff;
   logic [DIV_W-1:0] reload_q;
   logic [DIV_W-1:0] cnt_q;

   always_comb eff = (div_i < MIN_HALF) ? MIN_HALF : div_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= MIN_HALF;
         cnt_q    <= '0;
      end else if (load_i) begin
         reload_q <= eff;
         cnt_q    <= eff - DIV_W'(1);
      end else if (run_i) begin
         if (cnt_q == '0) cnt_q <= reload_q - DIV_W'(1);
         else             cnt_q <= cnt_q - DIV_W'(1);
      end
   end

   assign tick_o = run_i && (cnt_q == '0);

endmodule

// File: rtl/rdr_shift_in.sv
module rdr_shift_in #(
   parameter int FRAME_BITS = 13,
   parameter int DATA_BITS  = 12,
   parameter bit MSB_FIRST  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_i,
   input  logic                 sample_i,
   input  logic                 sdata_i,
   output logic [DATA_BITS-1:0] word_o
);
   localparam int LEAD_BITS = FRAME_BITS - DATA_BITS;

   logic [FRAME_BITS-1:0] sr_q;

   generate
      if (MSB_FIRST) begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        sr_q <= '0;
            else if (clr_i)    sr_q <= '0;
            else if (sample_i) sr_q <= {sr_q[FRAME_BITS-2:0], sdata_i};
         end
         assign word_o = sr_q[DATA_BITS-1:0];
      end else begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        sr_q <= '0;
            else if (clr_i)    sr_q <= '0;
            else if (sample_i) sr_q <= {sdata_i, sr_q[FRAME_BITS-1:1]};
         end
         assign word_o = sr_q[FRAME_BITS-1:LEAD_BITS];
      end
   endgenerate

endmodule

// File: rtl/rdr_ctrl.sv
module rdr_ctrl #(
   parameter int FRAME_BITS = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic tick_i,
   output logic load_o,
   output logic run_o,
   output logic sample_o,
   output logic finish_o,
   output logic sel_n_o,
   output logic sclk_o,
   output logic done_o
);
   import rdr_pkg::*;

   localparam int CNT_W = rdr_cnt_width(FRAME_BITS);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

   rdr_state_e       state_q;
   logic [CNT_W-1:0] bit_q;
   logic             sclk_q;
   logic             sel_n_q;
   logic             done_q;

   assign load_o   = (state_q == RDR_IDLE) && req_i;
   assign run_o    = (state_q != RDR_IDLE);
   assign sample_o = (state_q == RDR_SHIFT) && tick_i && !sclk_q;
   assign finish_o = (state_q == RDR_TAIL) && tick_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RDR_IDLE;
         bit_q   <= '0;
         sclk_q  <= 1'b1;
         sel_n_q <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            RDR_IDLE: begin
               if (req_i) begin
                  state_q <= RDR_SHIFT;
                  bit_q   <= '0;
                  sel_n_q <= 1'b0;
                  sclk_q  <= 1'b1;
               end
            end
            RDR_SHIFT: begin
               if (tick_i) begin
                  if (sclk_q) begin
                     sclk_q <= 1'b0;
                  end else begin
                     sclk_q <= 1'b1;
                     bit_q  <= bit_q + CNT_W'(1);
                     if (bit_q == LAST_BIT) state_q <= RDR_TAIL;
                  end
               end
            end
            RDR_TAIL: begin
               if (tick_i) begin
                  sel_n_q <= 1'b1;
                  done_q  <= 1'b1;
                  state_q <= RDR_IDLE;
               end
            end
            default: state_q <= RDR_IDLE;
         endcase
      end
   end

   assign sel_n_o = sel_n_q;
   assign sclk_o  = sclk_q;
   assign done_o  = done_q;

endmodule

// File: rtl/abs_pos_reader.sv
module abs_pos_reader #(
   parameter int DATA_BITS = 12,
   parameter int LEAD_BITS = 1,
   parameter int DIV_W     = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_i,
   input  logic [DIV_W-1:0]     half_div_i,
   input  logic                 sdata_i,
   output logic                 sel_n_o,
   output logic                 sclk_o,
   output logic [DATA_BITS-1:0] pos_o,
   output logic                 done_o
);
   localparam int FRAME_BITS = LEAD_BITS + DATA_BITS;

   initial begin
      if (DATA_BITS < 1) $fatal(1, "abs_pos_reader: DATA_BITS must be at least 1");
      if (LEAD_BITS < 1) $fatal(1, "abs_pos_reader: LEAD_BITS must be at least 1");
      if (DIV_W < 2)     $fatal(1, "abs_pos_reader: DIV_W must be at least 2");
   end

   logic                 load;
   logic                 run;
   logic                 tick;
   logic                 sample;
   logic                 finish;
   logic [DATA_BITS-1:0] word;
   logic [DATA_BITS-1:0] pos_q;

   rdr_half_timer #(.DIV_W(DIV_W)) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .div_i  (half_div_i),
      .run_i  (run),
      .tick_o (tick)
   );

   rdr_ctrl #(.FRAME_BITS(FRAME_BITS)) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (req_i),
      .tick_i   (tick),
      .load_o   (load),
      .run_o    (run),
      .sample_o (sample),
      .finish_o (finish),
      .sel_n_o  (sel_n_o),
      .sclk_o   (sclk_o),
      .done_o   (done_o)
   );

   rdr_shift_in #(
      .FRAME_BITS (FRAME_BITS),
      .DATA_BITS  (DATA_BITS),
      .MSB_FIRST  (MSB_FIRST)
   ) shift_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (load),
      .sample_i (sample),
      .sdata_i  (sdata_i),
      .word_o   (word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pos_q <= '0;
      else if (finish) pos_q <= word;
   end

   assign pos_o = pos_q;

endmodule

// File: rtl/rdr_checker.sv
module rdr_checker #(
   parameter int DATA_BITS = 12
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_i,
   input logic                 sel_n_o,
   input logic                 sclk_o,
   input logic [DATA_BITS-1:0] pos_o,
   input logic                 done_o
);

   AST_IDLE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n_o |-> sclk_o) else $error("idle sclk low"); // R2

   AST_REQ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && sel_n_o) |=> !sel_n_o) else $error("request not taken"); // R1

   AST_SCLK_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sclk_o) |-> !sel_n_o) else $error("sclk moved outside frame"); // R3

   AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $rose(sel_n_o)) else $error("done not at select release"); // R6

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o) else $error("done longer than one cycle"); // R7

   AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(pos_o)) else $error("position moved without done"); // R8

   AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !sel_n_o && !$rose(sel_n_o)) |=> (!sel_n_o || done_o)) else $error("busy request disturbed frame"); // R9

endmodule

bind abs_pos_reader rdr_checker #(.DATA_BITS(DATA_BITS)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .req_i   (req_i),
   .sel_n_o (sel_n_o),
   .sclk_o  (sclk_o),
   .pos_o   (pos_o),
   .done_o  (done_o)
);

// File: tb/abs_pos_reader_tb.sv
module abs_pos_reader_tb_top;

   localparam int DB = 12;
   localparam int FB = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_i = 1'b0;
   logic [7:0]    half_div_i = 8'd0;
   logic          sdata_i = 1'b0;
   logic          sel_n_o;
   logic          sclk_o;
   logic [DB-1:0] pos_o;
   logic          done_o;

   int            checks = 0;
   int            errors = 0;
   logic [FB-1:0] frame_q = '0;

   always #10 clk = ~clk;

   abs_pos_reader dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i),
      .half_div_i (half_div_i),
      .sdata_i    (sdata_i),
      .sel_n_o    (sel_n_o),
      .sclk_o     (sclk_o),
      .pos_o      (pos_o),
      .done_o     (done_o)
   );

   function automatic int exp_half(input int d);
      return (d < 2) ? 2 : d;
   endfunction

   function automatic logic [DB-1:0] exp_word(input logic [FB-1:0] f);
      return f[DB-1:0];
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // converter model: garbage before first fall, then one bit per falling edge
   initial begin
      forever begin
         @(negedge sel_n_o);
         sdata_i = 1'($urandom);
         for (int i = 0; i < FB; i++) begin
            @(negedge sclk_o or posedge sel_n_o);
            if (sel_n_o) break;
            sdata_i = frame_q[FB-1-i];
         end
      end
   end

   task automatic run_frame(input int div, input logic [DB-1:0] data, input bit poke);
      int h, k, last, falls, rises, bad, done_k;
      logic prev_sclk;
      logic [DB-1:0] pos_before;
      h = exp_half(div);
      frame_q = {1'($urandom), data};
      @(negedge clk);
      half_div_i = 8'(div);
      req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      chk(sel_n_o == 1'b0, "R1", "select low after request", int'(sel_n_o), 0);
      chk(sclk_o == 1'b1, "R1", "sclk high at frame start", int'(sclk_o), 1);
      k = 0; last = 0; falls = 0; rises = 0; bad = 0; done_k = -1;
      prev_sclk = 1'b1;
      pos_before = pos_o;
      while (done_k < 0 && k < 40 * h) begin
         @(negedge clk);
         k++;
         req_i = (poke && k == 5 * h) ? 1'b1 : 1'b0;
         if (!done_o && pos_o != pos_before) bad++;
         if (sclk_o != prev_sclk) begin
            if (k - last != h) bad++;
            last = k;
            if (!sclk_o) falls++; else rises++;
            prev_sclk = sclk_o;
         end
         if (done_o) done_k = k;
      end
      req_i = 1'b0;
      chk(bad == 0, "R3", "half-period or hold errors", bad, 0);
      chk(falls == FB && rises == FB, "R4", "falling/rising edge count",
          falls * 256 + rises, FB * 256 + FB);
      chk(done_k >= 0 && done_k - last == h, "R6", "tail length to release", done_k - last, h);
      chk(sel_n_o == 1'b1, "R6", "select high at done", int'(sel_n_o), 1);
      chk(pos_o == exp_word(frame_q), "R5", "captured position", int'(pos_o), int'(exp_word(frame_q)));
      @(negedge clk);
      chk(done_o == 1'b0, "R7", "done single cycle", int'(done_o), 0);
      if (poke) begin
         for (int i = 0; i < 3 * h; i++) begin
            @(negedge clk);
            if (!sel_n_o) bad++;
         end
         chk(bad == 0, "R9", "busy request started a frame", bad, 0);
      end
   endtask

   task automatic hold_check(input int cycles);
      logic [DB-1:0] p;
      int moved;
      p = pos_o; moved = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (pos_o != p || done_o || !sel_n_o) moved++;
      end
      chk(moved == 0, "R8", "position held between frames", moved, 0);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk(sel_n_o == 1'b1 && sclk_o == 1'b1, "R2", "idle lines in reset",
          {sel_n_o, sclk_o}, 3);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pos_o == '0 && done_o == 1'b0, "R2", "reset position and done",
          int'(pos_o) + int'(done_o), 0);
      chk(sel_n_o == 1'b1 && sclk_o == 1'b1, "R2", "idle lines after reset",
          {sel_n_o, sclk_o}, 3);
      // directed
      run_frame(0, 12'hA5C, 1'b0);        // R10 div 0 -> 2
      run_frame(1, 12'h3C1, 1'b0);        // R10 div 1 -> 2
      run_frame(2, 12'hFFF, 1'b0);
      hold_check(17);
      run_frame(7, 12'h000, 1'b0);
      run_frame(5, 12'h801, 1'b1);        // R9 busy request
      run_frame(3, 12'h001, 1'b0);
      // random
      for (int n = 0; n < 40; n++) begin
         run_frame(int'($urandom_range(12, 2)), DB'($urandom), ($urandom_range(7, 0) == 0));
         if ($urandom_range(3, 0) == 0) hold_check(int'($urandom_range(30, 1)));
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule